// File: doc/BRIEF.md
# Quarter-Rate Polyphase Digital Downconverter

This block turns a stream of real ADC samples, whose band of interest sits at one quarter of the sample rate, into complex baseband I/Q samples at one quarter of the input rate. It has no oscillator and no mixer multiplier. At fs/4 the cosine and sine carriers take only the values 0 and ±1, so mixing becomes routing with sign flips. Samples in phases 0 and 2 of each group of four feed the in-phase delay line, and phase 2 is negated. Samples in phases 1 and 3 feed the quadrature delay line, and phase 3 is negated.

A 31-tap real, symmetric low-pass filter then runs only at the decimated output points. Mirrored taps are summed before the multiply, so one product serves two samples. The filter arithmetic is shared in time: the datapath clock runs at four or more times the input sample rate, and one multiplier per branch walks through the eight pre-added pairs of that branch. The result is rounded and saturated back to the input word width.

The coefficients are loaded through a small write port that holds the 16 unique values. The center tap is at index 15.

Top module: `qddc_top`

## Requirements
- R1: After reset, the first accepted sample has phase 0, and the phase advances by one (mod 4) on each accepted sample. The mixed sample is +x in phase 0 and −x in phase 2, routed to the in-phase branch. It is +x in phase 1 and −x in phase 3, routed to the quadrature branch. The other branch receives 0 for that sample.
- R2: Each fourth accepted sample (phase 3) produces exactly one output. `out_valid` is high for one cycle, 9 clock edges after the edge that accepted that sample, and is low in every other cycle.
- R3: With n the index of the phase-3 sample, out_i = Σ_{j=0..30} h[j]·mi[n−j] and out_q = Σ h[j]·mq[n−j]. Here mi and mq are the R1 mixed sequences, and samples before reset count as 0. Values are shown before the R5/R6 scaling.
- R4: A write with `coef_we`=1, address a (0..15) and signed data v sets both h[a] and h[30−a] to v. Address 15 is the center tap. A write takes effect for computations started after it. Reset sets all coefficients to 0.
- R5: Coefficients are signed Q1.15. The sum s is scaled as floor((s + 2^14) / 2^15), which rounds halves toward +∞.
- R6: A scaled value above 8191 gives 8191. A value below −8192 gives −8192. Inputs and outputs are 14-bit two's complement.
- R7: A synchronous reset clears both delay lines, the phase, any computation in flight and both outputs. `out_valid` is low in the cycle after a reset edge.
- R8: The caller keeps accepted samples at least 4 clock cycles apart. Back-to-back samples at exactly that spacing are processed without loss.
- R9: Between output pulses, `out_i` and `out_q` hold their last value (0 after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock, at least 4× the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_data` for one cycle |
| in_data | input | 14 | Real input sample, signed |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 4 | Unique tap index 0..15 |
| coef_data | input | 16 | Signed Q1.15 coefficient |
| out_valid | output | 1 | One-cycle output strobe |
| out_i | output | 14 | In-phase result, signed |
| out_q | output | 14 | Quadrature result, signed |

## Verification
The assertions check, on every cycle, the properties that depend only on the handshake and the phase. These are:
- the phase count against the number of accepted samples;
- the fixed 9-edge distance from each phase-3 sample to its output strobe;
- the minimum sample spacing;
- that the outputs hold between strobes;
- the quiet outputs after reset.

The numeric behaviour can only be shown by the bench scenarios, which compare every cycle against a sum over the full input history. That behaviour covers the sign and routing of each phase, symmetric coefficient loading, half-way rounding in both signs, saturation at both rails, and a reset that cuts a group short.

// File: rtl/qddc_pkg.sv
package qddc_pkg;

    // Commutation phase of the next accepted sample.
    // Bit 0 selects the quadrature branch, bit 1 selects negation.
    typedef enum logic [1:0] {
        PH_I_POS = 2'd0,
        PH_Q_POS = 2'd1,
        PH_I_NEG = 2'd2,
        PH_Q_NEG = 2'd3
    } phase_e;

    function automatic logic phase_is_quad(input phase_e p);
        return p[0];
    endfunction

    function automatic logic phase_negates(input phase_e p);
        return p[1];
    endfunction

    function automatic phase_e phase_advance(input phase_e p);
        return phase_e'(p + 2'd1);
    endfunction

    function automatic logic phase_closes_group(input phase_e p);
        return p == PH_Q_NEG;
    endfunction

endpackage

// File: rtl/qddc_commutator.sv
module qddc_commutator
    import qddc_pkg::*;
#(
    parameter int DATA_W  = 14,
    parameter int I_DEPTH = 15,
    parameter int Q_DEPTH = 16,
    localparam int MW     = DATA_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [DATA_W-1:0]        in_data,
    output phase_e                   phase,
    output logic                     group_done,
    output logic signed [MW-1:0]     i_line [I_DEPTH],
    output logic signed [MW-1:0]     q_line [Q_DEPTH]
);

    logic signed [MW-1:0] widened;
    logic signed [MW-1:0] mixed;

    // One extra bit so that negating the most negative input cannot wrap.
    assign widened = {in_data[DATA_W-1], in_data};
    assign mixed   = phase_negates(phase) ? -widened : widened;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_I_POS;
            group_done <= 1'b0;
            for (int t = 0; t < I_DEPTH; t++) i_line[t] <= '0;
            for (int t = 0; t < Q_DEPTH; t++) q_line[t] <= '0;
        end else begin
            group_done <= in_valid && phase_closes_group(phase);
            if (in_valid) begin
                phase <= phase_advance(phase);
                if (phase_is_quad(phase)) begin
                    for (int t = Q_DEPTH - 1; t > 0; t--) q_line[t] <= q_line[t-1];
                    q_line[0] <= mixed;
                end else begin
                    for (int t = I_DEPTH - 1; t > 0; t--) i_line[t] <= i_line[t-1];
                    i_line[0] <= mixed;
                end
            end
        end
    end

endmodule

// File: rtl/qddc_preadd.sv
module qddc_preadd #(
    parameter int MW      = 15,
    parameter int I_DEPTH = 15,
    parameter int Q_DEPTH = 16,
    parameter int STEPS   = 8,
    localparam int PW     = MW + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 capture,
    input  logic signed [MW-1:0] i_line [I_DEPTH],
    input  logic signed [MW-1:0] q_line [Q_DEPTH],
    output logic signed [PW-1:0] pre_i  [STEPS],
    output logic signed [PW-1:0] pre_q  [STEPS]
);

    for (genvar s = 0; s < STEPS; s++) begin : g_pair
        logic signed [PW-1:0] sum_i;
        logic signed [PW-1:0] sum_q;

        // In-phase line has odd length: its middle element has no mate.
        if (2 * s == I_DEPTH - 1) begin : g_center
            assign sum_i = PW'(i_line[s]);
        end else begin : g_mirror
            assign sum_i = PW'(i_line[s]) + PW'(i_line[I_DEPTH-1-s]);
        end
        assign sum_q = PW'(q_line[s]) + PW'(q_line[Q_DEPTH-1-s]);

        always_ff @(posedge clk) begin
            if (rst) begin
                pre_i[s] <= '0;
                pre_q[s] <= '0;
            end else if (capture) begin
                pre_i[s] <= sum_i;
                pre_q[s] <= sum_q;
            end
        end
    end

endmodule

// File: rtl/qddc_coef_bank.sv
module qddc_coef_bank #(
    parameter int COEF_W = 16,
    parameter int HALF   = 16,
    parameter int AW     = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [AW-1:0]            addr,
    input  logic [COEF_W-1:0]        data,
    output logic signed [COEF_W-1:0] h [HALF]
);

    for (genvar a = 0; a < HALF; a++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                h[a] <= '0;
            else if (we && addr == AW'(a))
                h[a] <= data;
        end
    end

endmodule

// File: rtl/qddc_mac.sv
module qddc_mac #(
    parameter int PW     = 16,
    parameter int COEF_W = 16,
    parameter int STEPS  = 8,
    parameter int DATA_W = 14,
    localparam int SW    = $clog2(STEPS),
    localparam int ACC_W = PW + COEF_W + SW
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     en,
    input  logic                     last,
    input  logic [SW-1:0]            sel,
    input  logic signed [PW-1:0]     pre  [STEPS],
    input  logic signed [COEF_W-1:0] coef [STEPS],
    output logic signed [DATA_W-1:0] y
);

    localparam longint HI_L = (longint'(1) << (DATA_W - 1)) - 1;
    localparam logic signed [ACC_W-1:0] Y_HI    = ACC_W'(HI_L);
    localparam logic signed [ACC_W-1:0] Y_LO    = ACC_W'(-HI_L - 1);
    localparam logic signed [ACC_W-1:0] RND_ADD = ACC_W'(longint'(1) << (COEF_W - 2));

    logic signed [PW+COEF_W-1:0] prod;
    logic signed [ACC_W-1:0]     acc;
    logic signed [ACC_W-1:0]     sum;
    logic signed [ACC_W-1:0]     scaled;

    assign prod   = pre[sel] * coef[sel];
    assign sum    = acc + ACC_W'(prod);
    assign scaled = (sum + RND_ADD) >>> (COEF_W - 1);

    function automatic logic signed [DATA_W-1:0] clamp(input logic signed [ACC_W-1:0] v);
        if (v > Y_HI) return Y_HI[DATA_W-1:0];
        if (v < Y_LO) return Y_LO[DATA_W-1:0];
        return v[DATA_W-1:0];
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            y   <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= sum;
            if (last) y <= clamp(scaled);
        end
    end

endmodule

// File: rtl/qddc_top.sv
module qddc_top
    import qddc_pkg::*;
#(
    parameter int DATA_W  = 14,
    parameter int COEF_W  = 16,
    parameter int TAPS    = 31,   // must be of the form 4m+3
    parameter int COEF_AW = $clog2((TAPS + 1) / 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              coef_we,
    input  logic [COEF_AW-1:0] coef_addr,
    input  logic [COEF_W-1:0] coef_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_i,
    output logic [DATA_W-1:0] out_q
);

    localparam int MW      = DATA_W + 1;
    localparam int PW      = MW + 1;
    localparam int I_DEPTH = (TAPS - 1) / 2;
    localparam int Q_DEPTH = (TAPS + 1) / 2;
    localparam int HALF    = Q_DEPTH;
    localparam int STEPS   = Q_DEPTH / 2;
    localparam int SW      = $clog2(STEPS);

    phase_e                     phase_w;
    logic                       group_done;
    logic signed [MW-1:0]       i_line [I_DEPTH];
    logic signed [MW-1:0]       q_line [Q_DEPTH];
    logic signed [PW-1:0]       pre_i  [STEPS];
    logic signed [PW-1:0]       pre_q  [STEPS];
    logic signed [COEF_W-1:0]   h      [HALF];
    logic signed [COEF_W-1:0]   coef_i [STEPS];
    logic signed [COEF_W-1:0]   coef_q [STEPS];
    logic signed [DATA_W-1:0]   y_i;
    logic signed [DATA_W-1:0]   y_q;
    logic                       run;
    logic [SW-1:0]              step;
    logic                       last;

    // Even sample slots meet odd taps; odd slots meet even taps.
    for (genvar s = 0; s < STEPS; s++) begin : g_coef_route
        assign coef_i[s] = h[2*s+1];
        assign coef_q[s] = h[2*s];
    end

    qddc_commutator #(.DATA_W(DATA_W), .I_DEPTH(I_DEPTH), .Q_DEPTH(Q_DEPTH)) u_comm (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .phase(phase_w), .group_done(group_done), .i_line(i_line), .q_line(q_line)
    );

    qddc_preadd #(.MW(MW), .I_DEPTH(I_DEPTH), .Q_DEPTH(Q_DEPTH), .STEPS(STEPS)) u_pre (
        .clk(clk), .rst(rst), .capture(group_done),
        .i_line(i_line), .q_line(q_line), .pre_i(pre_i), .pre_q(pre_q)
    );

    qddc_coef_bank #(.COEF_W(COEF_W), .HALF(HALF), .AW(COEF_AW)) u_coef (
        .clk(clk), .rst(rst), .we(coef_we), .addr(coef_addr), .data(coef_data), .h(h)
    );

    // Sequencer: one pre-added pair per cycle on each branch.
    assign last = run && (step == SW'(STEPS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            run       <= 1'b0;
            step      <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= last;
            if (group_done) begin
                run  <= 1'b1;
                step <= '0;
            end else if (run) begin
                step <= step + 1'b1;
                if (last) run <= 1'b0;
            end
        end
    end

    qddc_mac #(.PW(PW), .COEF_W(COEF_W), .STEPS(STEPS), .DATA_W(DATA_W)) u_mac_i (
        .clk(clk), .rst(rst), .clr(group_done), .en(run), .last(last),
        .sel(step), .pre(pre_i), .coef(coef_i), .y(y_i)
    );

    qddc_mac #(.PW(PW), .COEF_W(COEF_W), .STEPS(STEPS), .DATA_W(DATA_W)) u_mac_q (
        .clk(clk), .rst(rst), .clr(group_done), .en(run), .last(last),
        .sel(step), .pre(pre_q), .coef(coef_q), .y(y_q)
    );

    assign out_i = y_i;
    assign out_q = y_q;

endmodule

// File: rtl/qddc_checker.sv
module qddc_checker #(
    parameter int DATA_W = 14,
    parameter int TAPS   = 31,
    localparam int LAT   = (TAPS + 1) / 4 + 2
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_i,
    input logic [DATA_W-1:0] out_q,
    input logic [1:0]        phase
);

    logic [1:0]     accepted;
    logic [1:0]     since;
    logic [LAT-1:0] pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            accepted <= '0;
            since    <= 2'd3;
            pend     <= '0;
        end else begin
            if (in_valid) accepted <= accepted + 2'd1;
            since <= in_valid ? 2'd0 : (since == 2'd3 ? 2'd3 : since + 2'd1);
            pend  <= {pend[LAT-2:0], in_valid && accepted == 2'd3};
        end
    end

    // R1: phase equals the number of samples accepted since reset, mod 4
    p_phase_track_r1: assert property (@(posedge clk) disable iff (rst)
        phase == accepted);

    // R2: strobe exactly 9 edges after each fourth sample, never otherwise
    p_out_latency_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid == pend[LAT-1]);

    // R8: samples arrive at least 4 cycles apart
    p_min_spacing_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> since == 2'd3);

    // R9: outputs hold between strobes
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(rst)) |-> ($stable(out_i) && $stable(out_q)));

    // R7: reset silences the output and restarts the phase
    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (!out_valid && phase == 2'd0 && out_i == '0 && out_q == '0));

endmodule

bind qddc_top qddc_checker #(.DATA_W(DATA_W), .TAPS(TAPS)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
    .out_i(out_i), .out_q(out_q), .phase(phase_w)
);

// File: tb/tb_qddc_top.sv
`timescale 1ns/1ps
module tb_qddc_top;

    localparam int NT = 31;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [13:0] in_data = '0;
    logic        coef_we = 1'b0;
    logic [3:0]  coef_addr = '0;
    logic [15:0] coef_data = '0;
    logic        out_valid;
    logic [13:0] out_i;
    logic [13:0] out_q;

    qddc_top dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    always #2 clk = ~clk;   // 250 MHz

    typedef struct {
        longint due;
        int     yi;
        int     yq;
    } exp_t;

    int     checks = 0;
    int     fails = 0;
    longint ec = 0;
    bit     rst_at_edge = 1'b1;
    int     hist[$];
    exp_t   expq[$];
    int     h[NT];
    int     last_i = 0;
    int     last_q = 0;
    string  tag = "R7";

    always @(posedge clk) begin
        ec++;
        rst_at_edge = rst;
    end

    function automatic int scale_sat(longint s);
        longint r;
        r = (s + 64'sd16384) >>> 15;
        if (r > 8191) r = 8191;
        if (r < -8192) r = -8192;
        return int'(r);
    endfunction

    // Reference: full convolution over the mixed history (R1, R3, R5, R6)
    task automatic model_push(input int x);
        int n;
        longint si, sq;
        exp_t e;
        hist.push_back(x);
        n = hist.size() - 1;
        if (n % 4 == 3) begin
            si = 0;
            sq = 0;
            for (int j = 0; j < NT; j++) begin
                int m;
                int v;
                m = n - j;
                if (m >= 0) begin
                    v = hist[m];
                    case (m % 4)
                        0: si += longint'(h[j]) * v;
                        1: sq += longint'(h[j]) * v;
                        2: si -= longint'(h[j]) * v;
                        default: sq -= longint'(h[j]) * v;
                    endcase
                end
            end
            e.due = ec + 10;
            e.yi  = scale_sat(si);
            e.yq  = scale_sat(sq);
            expq.push_back(e);
        end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at edge %0d", req, what, act, expv, ec);
        end
    endtask

    // Per-cycle comparison, sampled at the falling edge
    always @(negedge clk) begin
        if (ec > 0) begin
            if (rst_at_edge) begin
                last_i = 0;
                last_q = 0;
                check(out_valid == 1'b0, "R7", "out_valid in reset", int'(out_valid), 0);
                check($signed(out_i) == 0 && $signed(out_q) == 0, "R7", "outputs in reset",
                      int'($signed(out_i)), 0);
            end else if (expq.size() > 0 && expq[0].due == ec) begin
                check(out_valid == 1'b1, "R2", "out_valid at due edge", int'(out_valid), 1);
                check($signed(out_i) == expq[0].yi, tag, "out_i", int'($signed(out_i)), expq[0].yi);
                check($signed(out_q) == expq[0].yq, tag, "out_q", int'($signed(out_q)), expq[0].yq);
                last_i = expq[0].yi;
                last_q = expq[0].yq;
                void'(expq.pop_front());
            end else begin
                check(out_valid == 1'b0, "R2", "out_valid off-slot", int'(out_valid), 0);
                check($signed(out_i) == last_i && $signed(out_q) == last_q, "R9",
                      "held out_i", int'($signed(out_i)), last_i);
            end
        end
    end

    task automatic do_reset(input int cycles);
        @(posedge clk); #1;
        rst = 1'b1;
        hist.delete();
        for (int k = expq.size() - 1; k >= 0; k--)
            if (expq[k].due > ec) expq.delete(k);
        for (int j = 0; j < NT; j++) h[j] = 0;
        repeat (cycles) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic write_coef(input int a, input int v);
        @(posedge clk); #1;
        coef_we = 1'b1;
        coef_addr = 4'(a);
        coef_data = 16'(v);
        h[a] = v;
        h[NT-1-a] = v;
        @(posedge clk); #1;
        coef_we = 1'b0;
    endtask

    task automatic send(input int x, input int gap);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_data = 14'(x);
        model_push(x);
        @(posedge clk); #1;
        in_valid = 1'b0;
        repeat (gap - 2) @(posedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic impulses(input int amp);
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 40; k++) send((k == p) ? amp : 0, 4);
        end
    endtask

    // Watchdog: counts as a failed check
    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int j = 0; j < NT; j++) h[j] = 0;
        idle(3);
        #1 rst = 1'b0;

        // R7: reset state already checked; zero coefficients give zero output
        tag = "R7";
        for (int k = 0; k < 8; k++) send(5000, 4);
        idle(16);

        // R1: impulse in each phase reveals routing and sign
        tag = "R1";
        for (int a = 0; a < 16; a++) write_coef(a, 1000 + 500 * a);
        impulses(6000);
        impulses(-8192);
        idle(16);

        // R4: one write sets both mirrored taps, center is unique
        tag = "R4";
        write_coef(0, -20000);
        write_coef(15, 30000);
        write_coef(7, 12345);
        for (int k = 0; k < 48; k++) send(k * 150 - 3000, 5);
        idle(16);

        // R5: only center tap at 0.5 exposes half-way rounding in both signs
        tag = "R5";
        for (int a = 0; a < 16; a++) write_coef(a, (a == 15) ? 16384 : 0);
        for (int k = 0; k < 64; k++) send((k % 2 == 0) ? (2 * k + 1) : -(2 * k + 1), 4);
        send(8191, 4); send(-8191, 4); send(-8192, 4); send(1, 4);
        for (int k = 0; k < 32; k++) send(k - 16, 4);
        idle(16);

        // R6: full-scale coefficients drive both rails
        tag = "R6";
        for (int a = 0; a < 16; a++) write_coef(a, 32767);
        for (int k = 0; k < 48; k++) send((k % 4 < 2) ? 8191 : -8192, 4);
        for (int k = 0; k < 48; k++) send((k % 4 < 2) ? -8192 : 8191, 4);
        idle(16);

        // R8: minimum spacing, random data
        tag = "R8";
        for (int a = 0; a < 16; a++) write_coef(a, int'($urandom_range(0, 16000)) - 8000);
        for (int k = 0; k < 96; k++) send(int'($urandom_range(0, 16383)) - 8192, 4);
        idle(16);

        // R3: random coefficients, data and spacing
        tag = "R3";
        for (int a = 0; a < 16; a++) write_coef(a, int'($urandom_range(0, 40000)) - 20000);
        for (int k = 0; k < 240; k++)
            send(int'($urandom_range(0, 16383)) - 8192, int'($urandom_range(4, 9)));
        idle(16);

        // R7: reset mid-group and mid-computation, then restart at phase 0
        tag = "R7";
        send(1234, 4); send(-999, 4);
        do_reset(2);
        for (int a = 0; a < 16; a++) write_coef(a, 2000 + 300 * a);
        for (int k = 0; k < 4; k++) send(3000 - 1000 * k, 4);
        idle(4);
        do_reset(1);
        for (int a = 0; a < 16; a++) write_coef(a, 2000 + 300 * a);
        impulses(4000);
        idle(20);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule